// File: doc/BRIEF.md
# Two-Port Byte-Lane Word Memory

This block is a 32-bit memory slave with two independent bus ports over one shared storage array. The fetch port only reads and is meant for instruction fetches. The data port reads and writes, and a 4-bit byte select on it masks individual bytes. The storage is made of four 8-bit lanes. Each lane is its own two-port array: the fetch port reads on one side, and the data port reads or writes on the other.

Each port uses a strobe and acknowledge handshake. A strobe is accepted in every cycle it is high, so the block never stalls. The acknowledge is a response-valid pulse that cannot be held off. It comes one cycle after each accepted strobe, with the read data on the same cycle. A master may therefore issue a new strobe on every cycle. Each port decodes only its word index, so the two ports can sit at different bus bases and still reach the same contents.

Top module: `bdr_ram`

## Requirements
- R1: Each port's acknowledge is high in exactly those cycles that follow a cycle in which that port's strobe was high, and is low otherwise.
- R2: A fetch strobe returns on `f_dat`, in the acknowledge cycle, the full 32-bit word stored at the addressed entry.
- R3: A data strobe with `d_we`=1 writes bits [8n+7:8n] of `d_wdat` into lane n for each n where `d_sel[n]`=1. Lanes with `d_sel[n]`=0 keep their stored byte.
- R4: A data strobe with `d_we`=0 returns the stored byte of each selected lane on `d_rdat` in the acknowledge cycle. The output byte of an unselected lane keeps its previous value.
- R5: Both ports see the same contents, so a word written through the data port is read back unchanged through the fetch port.
- R6: The entry is chosen by address bits [AW+1:2] only. Bits [1:0] and the bits above AW+1 are ignored, so a data address with base 0x80000000 and a fetch address with base 0x00000000 reach the same entry.
- R7: Strobes on consecutive cycles to different addresses each return their own word, one cycle after the address was presented.
- R8: When the data port writes a word, the fetch port reading that same word in the same cycle returns the old contents. The data port itself also returns the old contents on the selected lanes.
- R9: Fetch accesses never change the stored contents.
- R10: Reset clears both acknowledges and both read outputs to zero and leaves the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_stb | input | 1 | Fetch port strobe |
| f_adr | input | 32 | Fetch port byte address |
| f_dat | output | 32 | Fetch port read data |
| f_ack | output | 1 | Fetch port acknowledge |
| d_stb | input | 1 | Data port strobe |
| d_we | input | 1 | Data port write enable |
| d_adr | input | 32 | Data port byte address |
| d_sel | input | 4 | Data port byte select, bit n for lane n |
| d_wdat | input | 32 | Data port write data |
| d_rdat | output | 32 | Data port read data |
| d_ack | output | 1 | Data port acknowledge |

## Verification
The hardest cases to reach from the ports are a write on the data port that meets a fetch of the same word in the same cycle, and a partial-select read whose unselected output bytes must hold stale values. Directed sequences line both ports up on one index for the first case. A final random phase draws addresses from a narrow range with random select masks and random bases, so both cases recur many times. A reset in the middle of the run, followed by reads, shows that the stored contents survive reset.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int BUS_AW = 32;
endpackage

// File: rtl/bdr_ack.sv
module bdr_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= stb;
  end

  AST_ACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> ack); // R1
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> !ack); // R1
endmodule

// File: rtl/bdr_lane.sv
module bdr_lane #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read side only, never writes
  always_ff @(posedge clk) begin
    if (!rst_n)    a_q <= '0;
    else if (a_en) a_q <= mem[a_addr];
  end

  // read-first on the read/write side
  always_ff @(posedge clk) begin
    if (!rst_n)    b_q <= '0;
    else if (b_en) b_q <= mem[b_addr];
  end

  always_ff @(posedge clk) begin
    if (b_en && b_we) mem[b_addr] <= b_wd;
  end

  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |=> $stable(a_q)); // R2
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !b_en |=> $stable(b_q)); // R4
endmodule

// File: rtl/bdr_ram.sv
module bdr_ram
  import bdr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f_stb,
  input  logic [BUS_AW-1:0] f_adr,
  output logic [WORD_W-1:0] f_dat,
  output logic              f_ack,
  input  logic              d_stb,
  input  logic              d_we,
  input  logic [BUS_AW-1:0] d_adr,
  input  logic [LANES-1:0]  d_sel,
  input  logic [WORD_W-1:0] d_wdat,
  output logic [WORD_W-1:0] d_rdat,
  output logic              d_ack
);
  localparam int LSB = 2;

  logic [AW-1:0] f_idx;
  logic [AW-1:0] d_idx;

  assign f_idx = f_adr[AW+LSB-1:LSB];
  assign d_idx = d_adr[AW+LSB-1:LSB];

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    bdr_lane #(.AW(AW), .DW(LANE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_en   (f_stb),
      .a_addr (f_idx),
      .a_q    (f_dat[n*LANE_W +: LANE_W]),
      .b_en   (d_stb & d_sel[n]),
      .b_we   (d_we),
      .b_addr (d_idx),
      .b_wd   (d_wdat[n*LANE_W +: LANE_W]),
      .b_q    (d_rdat[n*LANE_W +: LANE_W])
    );
  end

  bdr_ack u_fack (.clk(clk), .rst_n(rst_n), .stb(f_stb), .ack(f_ack));
  bdr_ack u_dack (.clk(clk), .rst_n(rst_n), .stb(d_stb), .ack(d_ack));
endmodule

// File: tb/bdr_ram_test.sv
module bdr_ram_test;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        f_stb = 1'b0, d_stb = 1'b0, d_we = 1'b0;
  logic [31:0] f_adr = '0, d_adr = '0, d_wdat = '0;
  logic [3:0]  d_sel = '0;
  logic [31:0] f_dat, d_rdat;
  logic        f_ack, d_ack;

  int checks = 0;
  int errors = 0;
  bit armed  = 1'b0;
  bit done   = 1'b0;
  string tag = "R10";

  logic [31:0] m_mem [DEPTH];
  logic [31:0] e_fdat = '0, e_drdat = '0;
  logic        e_fack = 1'b0, e_dack = 1'b0;

  bdr_ram #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .f_stb(f_stb), .f_adr(f_adr), .f_dat(f_dat), .f_ack(f_ack),
    .d_stb(d_stb), .d_we(d_we), .d_adr(d_adr), .d_sel(d_sel),
    .d_wdat(d_wdat), .d_rdat(d_rdat), .d_ack(d_ack)
  );

  always #4 clk = ~clk;

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: check last cycle's results, drive inputs, advance model
  task automatic step(bit rst, bit fs, logic [31:0] fa,
                      bit ds, bit we, logic [31:0] da, logic [3:0] sel,
                      logic [31:0] wd);
    @(negedge clk);
    if (armed) begin
      cmp("f_ack",  {31'd0, f_ack}, {31'd0, e_fack});   // R1
      cmp("d_ack",  {31'd0, d_ack}, {31'd0, e_dack});   // R1
      cmp("f_dat",  f_dat,  e_fdat);
      cmp("d_rdat", d_rdat, e_drdat);
    end
    armed = 1'b1;
    rst_n = ~rst; f_stb = fs; f_adr = fa;
    d_stb = ds; d_we = we; d_adr = da; d_sel = sel; d_wdat = wd;
    if (rst) begin
      // R10: outputs cleared, contents kept
      e_fack = 0; e_dack = 0; e_fdat = '0; e_drdat = '0;
    end else begin
      int fi, di;
      fi = int'(fa[AW+1:2]);   // R6
      di = int'(da[AW+1:2]);
      e_fack = fs; e_dack = ds;
      if (fs) e_fdat = m_mem[fi];            // old contents, R8
      for (int n = 0; n < 4; n++)
        if (ds && sel[n]) e_drdat[8*n +: 8] = m_mem[di][8*n +: 8];
      if (ds && we)
        for (int n = 0; n < 4; n++)
          if (sel[n]) m_mem[di][8*n +: 8] = wd[8*n +: 8]; // R3
    end
  endtask

  task automatic idle();
    step(0, 0, '0, 0, 0, '0, 4'h0, '0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    tag = "R10";
    for (int i = 0; i < 3; i++) step(1, 0, '0, 0, 0, '0, 4'h0, '0);
    idle(); idle();

    // R3 fill every entry at data base with full select
    tag = "R3";
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, '0, 1, 1, 32'h8000_0000 | (i << 2), 4'hF, 32'hA5000000 ^ (i * 32'h01010101));
    idle();

    // R5 R6 R9: read through fetch port at base 0 with junk low bits
    tag = "R5/R6/R9";
    for (int i = 0; i < DEPTH; i += 7)
      step(0, 1, (i << 2) | 3, 0, 0, '0, 4'h0, '0);
    idle();
    step(0, 1, 32'h0000_0010, 0, 0, '0, 4'h0, '0);
    step(0, 0, '0, 1, 0, 32'h8000_0010, 4'hF, '0);
    idle();

    // R3 R4 byte-masked writes and partial reads
    tag = "R3/R4";
    step(0, 0, '0, 1, 1, 32'h8000_0020, 4'b0101, 32'h11223344);
    step(0, 0, '0, 1, 0, 32'h8000_0020, 4'b1111, '0);
    step(0, 0, '0, 1, 0, 32'h8000_0030, 4'b0010, '0);
    step(0, 0, '0, 1, 0, 32'h8000_0020, 4'b1000, '0);
    idle();

    // R1 R7 back-to-back on both ports, then gaps
    tag = "R1/R7";
    step(0, 1, 32'h40, 1, 0, 32'h8000_0044, 4'hF, '0);
    step(0, 1, 32'h48, 1, 0, 32'h8000_004C, 4'hF, '0);
    step(0, 1, 32'h50, 0, 0, '0, 4'h0, '0);
    idle();
    step(0, 0, '0, 1, 0, 32'h8000_0054, 4'hF, '0);
    idle(); idle();

    // R8 collision: write and fetch same word together
    tag = "R8";
    step(0, 1, 32'h60, 1, 1, 32'h8000_0060, 4'hF, 32'hDEADBEEF);
    step(0, 1, 32'h60, 1, 1, 32'h8000_0060, 4'b0011, 32'h0000CAFE);
    step(0, 1, 32'h60, 0, 0, '0, 4'h0, '0);
    idle();

    // R10 mid-run reset keeps contents
    tag = "R10";
    step(1, 0, '0, 0, 0, '0, 4'h0, '0);
    step(1, 0, '0, 0, 0, '0, 4'h0, '0);
    step(0, 1, 32'h60, 1, 0, 32'h8000_0020, 4'hF, '0);
    idle();

    // random mix on a narrow address range
    tag = "R1-mix R2 R4 R8";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] fa, da;
      fa = {$urandom_range(0, 1) ? 4'h8 : 4'h0, 20'($urandom), 6'($urandom_range(0, 15)), 2'($urandom)};
      da = {$urandom_range(0, 1) ? 4'h8 : 4'h0, 20'($urandom), 6'($urandom_range(0, 15)), 2'($urandom)};
      step(0, 1'($urandom), fa, 1'($urandom), 1'($urandom), da, 4'($urandom), $urandom);
    end
    idle(); idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule